// File: doc/BRIEF.md
# Counter-Array Timebase

This block is the shared 16-bit timebase of a programmable counter array. A free-running count advances on a tick taken from one of four sources. The sources are a slow division of the peripheral clock, a fast division of the peripheral clock, overflow pulses from timer 0, and falling edges on an external count pin. A run bit starts and stops the count. A gating option freezes it while the CPU is idle. When the count wraps from all ones to zero it raises a sticky overflow flag, and that flag drives an interrupt request when the request is enabled.

The block also collects event pulses from five compare/capture modules into sticky flags. Software can only clear those flags. A watchdog-enable output lets module 4 act as a watchdog. Software reaches all state through a byte-wide register bus. Writes take effect at the next clock edge, and reads are combinational from the address.

Top module: `pca_timebase`

## Requirements
- R1: After reset, every register reads 00h and both `irq` and `wdog_en` are 0. Mode bits 5..3 always read 0, and writing them has no effect.
- R2: When the mode source field (mode bits 2:1) is 00 and the count is active, the counter gains one for every 6 active clock edges. The divider phase restarts whenever the count is inactive.
- R3: When the source field is 01, the counter gains one for every 2 active clock edges.
- R4: When the source field is 10, the counter gains one for each clock cycle in which `t0_ovf` is high.
- R5: When the source field is 11, the counter gains exactly one per falling edge of `eci_pin`. The pin passes through a two-flop synchronizer, and pin periods down to 4 clocks are counted.
- R6: Control bit 6 is the run bit. While it is 0 the counter holds its value, and clearing it stops the count.
- R7: When mode bit 7 is 1 and `cpu_idle` is high, the counter holds. When mode bit 7 is 0, it keeps counting during idle.
- R8: A wrap from FFFFh to 0000h sets control bit 7. The bit is sticky. Writing 0 to it clears it, and writing 1 does not set it.
- R9: `irq` is high exactly while control bit 7 and mode bit 0 are both 1.
- R10: Control bits 4..0 are set by the matching `mod_evt` bit. Writing 0 clears a flag and writing 1 leaves it alone. A set in the same cycle as a clearing write wins.
- R11: `wdog_en` follows mode bit 6.
- R12: The counter's low byte (E9h) and high byte (F9h) are readable and writable. The mode register is at D9h and the control register is at D8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cpu_idle | input | 1 | CPU idle indication |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| eci_pin | input | 1 | External count pin (asynchronous) |
| mod_evt | input | 5 | Match/capture event pulses, one per module |
| irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Enables watchdog behaviour in module 4 |

## Verification
The bench builds the block with its default values: a 16-bit counter, dividers of 6 and 2, and five modules. With a divider of 6, every phase of the prescaler is reached by a sweep of run lengths from 1 to 21 cycles, and the count is checked against the floor of the active-edge count over the divider. Preloading FFFEh puts the wrap and its flag a few ticks away. Five modules make it practical to set and clear every flag one at a time, and to collide one set with a clearing write.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

    localparam logic [7:0] ADDR_CTRL   = 8'hD8;
    localparam logic [7:0] ADDR_MODE   = 8'hD9;
    localparam logic [7:0] ADDR_CNT_LO = 8'hE9;
    localparam logic [7:0] ADDR_CNT_HI = 8'hF9;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'b00,
        SRC_FAST = 2'b01,
        SRC_T0   = 2'b10,
        SRC_PIN  = 2'b11
    } src_e;

    typedef struct packed {
        logic       idle_gate;
        logic       wdog_on;
        logic [2:0] spare;
        src_e       src;
        logic       ovf_ie;
    } mode_t;

    function automatic mode_t mode_from_byte(input logic [7:0] b);
        mode_t m;
        m.idle_gate = b[7];
        m.wdog_on   = b[6];
        m.spare     = 3'b000;
        m.src       = src_e'(b[2:1]);
        m.ovf_ie    = b[0];
        return m;
    endfunction

endpackage

// File: rtl/ctb_tick_gen.sv
module ctb_tick_gen
    import ctb_pkg::*;
#(
    parameter int DIV_SLOW = 6,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  src_e src,
    input  logic t0_ovf,
    input  logic ext_pin,
    output logic tick
);
    localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

    logic [PW-1:0] pre;
    logic [PW-1:0] lim;
    logic          pre_hit;
    logic [2:0]    pin_sh;
    logic          pin_fall;

    assign lim     = (src == SRC_SLOW) ? LIM_SLOW : LIM_FAST;
    assign pre_hit = (pre == lim);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pre <= '0;
        end else if (pre_hit) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // two synchronizing flops plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_sh <= 3'b000;
        end else begin
            pin_sh <= {pin_sh[1:0], ext_pin};
        end
    end

    assign pin_fall = pin_sh[2] & ~pin_sh[1];

    always_comb begin
        unique case (src)
            SRC_SLOW, SRC_FAST: tick = active & pre_hit;
            SRC_T0:             tick = active & t0_ovf;
            SRC_PIN:            tick = active & pin_fall;
            default:            tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctb_counter.sv
module ctb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam int HI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    assign wrap = tick && !wr_lo && !wr_hi && (cnt == ALL_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[7:0]       <= wdata;
            if (wr_hi) cnt[CNT_W-1:8] <= wdata[HI_W-1:0];
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ctb_flags.sv
module ctb_flags #(
    parameter int NUM_MOD = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               run_wdata,
    input  logic               ovf_keep,
    input  logic [NUM_MOD-1:0] mod_keep,
    input  logic               wrap,
    input  logic [NUM_MOD-1:0] mod_evt,
    output logic               run,
    output logic               ovf_flag,
    output logic [NUM_MOD-1:0] mod_flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
        end else if (wr) begin
            run <= run_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
        end else if (wrap) begin
            ovf_flag <= 1'b1;
        end else if (wr && !ovf_keep) begin
            ovf_flag <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
        always_ff @(posedge clk) begin
            if (rst) begin
                mod_flags[g] <= 1'b0;
            end else if (mod_evt[g]) begin
                mod_flags[g] <= 1'b1;
            end else if (wr && !mod_keep[g]) begin
                mod_flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
    import ctb_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_SLOW = 6,
    parameter int DIV_FAST = 2,
    parameter int NUM_MOD  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               cpu_idle,
    input  logic               t0_ovf,
    input  logic               eci_pin,
    input  logic [NUM_MOD-1:0] mod_evt,
    output logic               irq,
    output logic               wdog_en
);
    mode_t              mode_q;
    logic               run;
    logic               active;
    logic               tick;
    logic               wrap;
    logic               ovf_flag;
    logic [NUM_MOD-1:0] mod_flags;
    logic [CNT_W-1:0]   cnt_val;
    logic               wr_mode, wr_ctrl, wr_lo, wr_hi, cnt_wr_any;
    logic [7:0]         ctrl_byte;

    assign wr_mode    = bus_wr && (bus_addr == ADDR_MODE);
    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_lo      = bus_wr && (bus_addr == ADDR_CNT_LO);
    assign wr_hi      = bus_wr && (bus_addr == ADDR_CNT_HI);
    assign cnt_wr_any = wr_lo || wr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_from_byte(8'h00);
        end else if (wr_mode) begin
            mode_q <= mode_from_byte(bus_wdata);
        end
    end

    assign active = run && !(mode_q.idle_gate && cpu_idle);

    ctb_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .src    (mode_q.src),
        .t0_ovf (t0_ovf),
        .ext_pin(eci_pin),
        .tick   (tick)
    );

    ctb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wr_lo(wr_lo),
        .wr_hi(wr_hi),
        .wdata(bus_wdata),
        .cnt  (cnt_val),
        .wrap (wrap)
    );

    ctb_flags #(.NUM_MOD(NUM_MOD)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_ctrl),
        .run_wdata(bus_wdata[6]),
        .ovf_keep (bus_wdata[7]),
        .mod_keep (bus_wdata[NUM_MOD-1:0]),
        .wrap     (wrap),
        .mod_evt  (mod_evt),
        .run      (run),
        .ovf_flag (ovf_flag),
        .mod_flags(mod_flags)
    );

    always_comb begin
        ctrl_byte              = '0;
        ctrl_byte[7]           = ovf_flag;
        ctrl_byte[6]           = run;
        ctrl_byte[NUM_MOD-1:0] = mod_flags;
    end

    always_comb begin
        case (bus_addr)
            ADDR_MODE:   bus_rdata = {mode_q.idle_gate, mode_q.wdog_on, 3'b000,
                                      mode_q.src, mode_q.ovf_ie};
            ADDR_CTRL:   bus_rdata = ctrl_byte;
            ADDR_CNT_LO: bus_rdata = cnt_val[7:0];
            ADDR_CNT_HI: bus_rdata = 8'(cnt_val[CNT_W-1:8]);
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq     = ovf_flag && mode_q.ovf_ie;
    assign wdog_en = mode_q.wdog_on;

endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
    parameter int CNT_W   = 16,
    parameter int NUM_MOD = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [CNT_W-1:0]   cnt,
    input logic               tick,
    input logic               cnt_wr,
    input logic               ctrl_wr,
    input logic               run,
    input logic               idle_gate,
    input logic               cpu_idle,
    input logic               ovf_flag,
    input logic               ovf_ie,
    input logic               irq,
    input logic [NUM_MOD-1:0] mod_evt,
    input logic [NUM_MOD-1:0] mod_flags
);
    a_r6_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> (cnt == $past(cnt)));

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (idle_gate && cpu_idle && !cnt_wr) |=> (cnt == $past(cnt)));

    a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && (&cnt)) |=> (ovf_flag && (cnt == '0)));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ctrl_wr) |=> ovf_flag);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_flag && ovf_ie));

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_chk
        a_r10_event_sets: assert property (@(posedge clk) disable iff (rst)
            mod_evt[g] |=> mod_flags[g]);
        a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (mod_flags[g] && !ctrl_wr) |=> mod_flags[g]);
    end

endmodule

bind pca_timebase ctb_checker #(.CNT_W(CNT_W), .NUM_MOD(NUM_MOD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_val),
    .tick     (tick),
    .cnt_wr   (cnt_wr_any),
    .ctrl_wr  (wr_ctrl),
    .run      (run),
    .idle_gate(mode_q.idle_gate),
    .cpu_idle (cpu_idle),
    .ovf_flag (ovf_flag),
    .ovf_ie   (mode_q.ovf_ie),
    .irq      (irq),
    .mod_evt  (mod_evt),
    .mod_flags(mod_flags)
);

// File: tb/pca_timebase_test.sv
module pca_timebase_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_idle = 1'b0;
    logic       t0_ovf = 1'b0;
    logic       eci_pin = 1'b1;
    logic [4:0] mod_evt = 5'b0;
    logic       irq;
    logic       wdog_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pca_timebase uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_idle(cpu_idle),
        .t0_ovf(t0_ovf), .eci_pin(eci_pin), .mod_evt(mod_evt),
        .irq(irq), .wdog_en(wdog_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic rd_cnt(output int v);
        int lo, hi;
        rd(8'hE9, lo);
        rd(8'hF9, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic set_cnt(input int v);
        wr(8'hE9, 8'(v));
        wr(8'hF9, 8'(v >> 8));
    endtask

    // run for k extra cycles: k+1 active edges in total
    task automatic run_for(input int k);
        wr(8'hD8, 8'h40);
        repeat (k) @(negedge clk);
        wr(8'hD8, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'hD9, v); chk("R1 mode", v, 0);
        rd(8'hD8, v); chk("R1 ctrl", v, 0);
        rd_cnt(v);    chk("R1 count", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 wdog_en", int'(wdog_en), 0);
        wr(8'hD9, 8'h38);
        rd(8'hD9, v); chk("R1 reserved bits", v, 0);

        // R12 byte access
        set_cnt(16'hC35A);
        rd_cnt(v); chk("R12 byte readback", v, 16'hC35A);

        // R2 / R3 sweeps across all prescaler phases
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k <= 20; k++) begin
                set_cnt(0);
                wr(8'hD9, 8'(s << 1));
                run_for(k);
                rd_cnt(v);
                if (s == 0) chk("R2 slow divide", v, (k + 1) / 6);
                else        chk("R3 fast divide", v, (k + 1) / 2);
            end
        end

        // R6 stopped counter ignores ticks
        set_cnt(16'h0010);
        wr(8'hD9, 8'h02);
        repeat (12) @(negedge clk);
        rd_cnt(v); chk("R6 hold while stopped", v, 16'h0010);

        // R4 timer 0 pulses with varied gaps
        for (int n = 1; n <= 6; n++) begin
            set_cnt(0);
            wr(8'hD9, 8'h04);
            wr(8'hD8, 8'h40);
            for (int p = 0; p < n; p++) begin
                @(negedge clk) t0_ovf = 1'b1;
                @(negedge clk) t0_ovf = 1'b0;
                repeat (p % 3) @(negedge clk);
            end
            wr(8'hD8, 8'h00);
            rd_cnt(v); chk("R4 timer0 pulses", v, n);
        end
        // R6 pulses with run cleared
        set_cnt(0);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk) t0_ovf = 1'b1;
            @(negedge clk) t0_ovf = 1'b0;
        end
        rd_cnt(v); chk("R6 t0 while stopped", v, 0);

        // R5 external pin, fastest and slower periods
        for (int half = 2; half <= 5; half += 3) begin
            for (int n = 1; n <= 8; n += 7) begin
                set_cnt(0);
                wr(8'hD9, 8'h06);
                wr(8'hD8, 8'h40);
                for (int e = 0; e < n; e++) begin
                    @(negedge clk) eci_pin = 1'b0;
                    repeat (half - 1) @(negedge clk);
                    @(negedge clk) eci_pin = 1'b1;
                    repeat (half - 1) @(negedge clk);
                end
                repeat (6) @(negedge clk);
                wr(8'hD8, 8'h00);
                rd_cnt(v); chk("R5 pin edges", v, n);
            end
        end

        // R7 idle gating
        cpu_idle = 1'b1;
        set_cnt(0);
        wr(8'hD9, 8'h80);
        run_for(11);
        rd_cnt(v); chk("R7 gated in idle", v, 0);
        set_cnt(0);
        wr(8'hD9, 8'h00);
        run_for(11);
        rd_cnt(v); chk("R7 runs in idle", v, 2);
        cpu_idle = 1'b0;

        // R8 / R9 overflow and interrupt
        set_cnt(16'hFFFE);
        wr(8'hD9, 8'h02);
        run_for(3);
        rd_cnt(v);    chk("R8 wrapped count", v, 0);
        rd(8'hD8, v); chk("R8 overflow flag", v, 8'h80);
        chk("R9 irq masked", int'(irq), 0);
        wr(8'hD9, 8'h03);
        @(negedge clk); chk("R9 irq enabled", int'(irq), 1);
        wr(8'hD8, 8'h80);
        rd(8'hD8, v); chk("R8 write 1 keeps flag", v, 8'h80);
        wr(8'hD8, 8'h00);
        rd(8'hD8, v); chk("R8 clear flag", v, 0);
        chk("R9 irq after clear", int'(irq), 0);
        wr(8'hD8, 8'h80);
        rd(8'hD8, v); chk("R8 write 1 no set", v, 0);

        // R10 module flags
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) mod_evt = 5'(1 << i);
            @(negedge clk) mod_evt = 5'b0;
            rd(8'hD8, v); chk("R10 flag set", v, (2 << i) - 1);
        end
        wr(8'hD8, 8'h1B);
        rd(8'hD8, v); chk("R10 partial clear", v, 8'h1B);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'hD8; bus_wdata = 8'h00; mod_evt = 5'b00100;
        @(posedge clk);
        #1 bus_wr = 1'b0; mod_evt = 5'b0;
        rd(8'hD8, v); chk("R10 set beats clear", v, 8'h04);
        wr(8'hD8, 8'h1F);
        rd(8'hD8, v); chk("R10 write 1 no set", v, 8'h04);

        // R11 watchdog enable
        wr(8'hD9, 8'h40);
        @(negedge clk); chk("R11 wdog on", int'(wdog_en), 1);
        wr(8'hD9, 8'h00);
        @(negedge clk); chk("R11 wdog off", int'(wdog_en), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule